// File: doc/BRIEF.md
# Timer Compare-Output Waveform Generator

This block is an 8-bit timer with a single compare channel that shapes a waveform on one output pin. A 3-bit waveform code picks one of four counting schemes. Free-running counting wraps at the all-ones value. Clear-on-match restarts the count at the compare value. Single-slope PWM counts up and wraps. Dual-slope PWM counts up and then back down. A 2-bit output-action field chooses what happens to the pin on a compare match and at the ends of the count. The count advances on every clock, since no prescaler is present.

Software-style state is loaded through three byte-wide write ports: two control bytes and the compare value. The same state can be read back combinationally. All pins are plain control and status signals. Nothing streams through the block, so there is no valid/ready handshake. A write strobe takes effect on the clock edge where it is high.

Top module: `cmpwave_timer`

## Requirements
- R1: While `rst` is high on a clock edge, the count, output level, output enable, overflow flag and all read-back bytes become zero.
- R2: Control byte A keeps waveform-code bits [1:0] in its bits [1:0] and the output action in bits [7:6]. Its bits [5:2] always read as zero, and writes to them are dropped. Control byte B keeps waveform-code bit [2] in its bit 3, and its other bits read as zero. Code 001 selects dual-slope PWM, 010 clear-on-match, 011 single-slope PWM, and every other code selects free-running counting.
- R3: `match_flag` is high in exactly the cycles where the count equals the active compare value. In non-PWM modes a compare write becomes active on the edge that takes it. `ovf_flag` is high for one cycle when the count has just reached 0 by wrapping from 255 or by counting down. In clear-on-match mode it is never high unless the count passes 255.
- R4: In free-running mode the count rises by one per clock and wraps from 255 to 0. In clear-on-match mode it counts from 0 up to the compare value and then returns to 0.
- R5: In the non-PWM modes, output action 01 toggles the pin on a match, 10 clears it and 11 sets it. The new level appears in the cycle after the match cycle.
- R6: In single-slope PWM the count runs 0 to 255 and wraps. With action 10 and compare C below 255, the pin is high while count <= C and low otherwise. Action 11 gives the inverse.
- R7: In dual-slope PWM the count steps by one, turns from 255 to 254 and from 0 to 1, and never repeats an end value.
- R8: In dual-slope PWM with action 10, a match while counting up clears the pin and a match while counting down sets it. Away from count C the pin is therefore high when count < C. Action 11 gives the inverse.
- R9: In both PWM modes, a compare value of 255 suppresses the match action. With action 10 the pin stays high and with action 11 it stays low. The level is applied at BOTTOM in single-slope and at TOP in dual-slope.
- R10: `wave_oe` is low, and `wave_out` is held at 0, when the action is 00 in any mode or 01 in a PWM mode. Otherwise `wave_oe` is high.
- R11: In PWM modes a compare write is read back at once but becomes active only after the next cycle in which the count is 255. The previous value keeps governing matches until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_a_we | input | 1 | Write strobe for control byte A |
| ctrl_a_wdata | input | 8 | Control byte A write data |
| ctrl_b_we | input | 1 | Write strobe for control byte B |
| ctrl_b_wdata | input | 8 | Control byte B write data |
| cmp_we | input | 1 | Write strobe for the compare value |
| cmp_wdata | input | W | Compare value write data |
| ctrl_a_rd | output | 8 | Control byte A read-back |
| ctrl_b_rd | output | 8 | Control byte B read-back |
| cmp_rd | output | W | Last written compare value |
| count | output | W | Current count |
| wave_out | output | 1 | Waveform output level |
| wave_oe | output | 1 | Output pin is driven by the timer |
| match_flag | output | 1 | Count equals the active compare value |
| ovf_flag | output | 1 | Count has just reached BOTTOM |

## Verification
The hardest case to reach is a compare value of 255 in dual-slope PWM. Such a value is loaded only while the count sits at 255, and its level is only applied at a later TOP. The pin therefore settles only after two full up-down periods, more than a thousand clocks. The stimulus writes the value, waits well beyond two periods, and then samples a whole period against the constant level. The deferred compare load is reached in a similar way: the bench follows the `count` port, writes a new compare value at a chosen count mid-period, and samples the pin and the match flag at counts on both sides of the next wrap.

// File: rtl/cmpwave_pkg.sv
package cmpwave_pkg;
  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    KIND_NORMAL,
    KIND_PHASE,
    KIND_CTC,
    KIND_FAST
  } kind_e;

  typedef enum logic [1:0] {
    OM_OFF  = 2'b00,
    OM_ALT  = 2'b01,
    OM_LOW  = 2'b10,
    OM_HIGH = 2'b11
  } om_e;

  function automatic kind_e decode_kind(input logic [2:0] code);
    case (code)
      3'b001:  return KIND_PHASE;
      3'b010:  return KIND_CTC;
      3'b011:  return KIND_FAST;
      default: return KIND_NORMAL;
    endcase
  endfunction

  function automatic logic is_pwm(input kind_e k);
    return (k == KIND_PHASE) || (k == KIND_FAST);
  endfunction
endpackage

// File: rtl/cmpwave_regs.sv
module cmpwave_regs
  import cmpwave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_a_we,
  input  logic [CTRL_W-1:0] ctrl_a_wdata,
  input  logic              ctrl_b_we,
  input  logic [CTRL_W-1:0] ctrl_b_wdata,
  input  logic              cmp_we,
  input  logic [W-1:0]      cmp_wdata,
  input  logic [W-1:0]      cnt,
  output kind_e             kind,
  output om_e               om,
  output logic [CTRL_W-1:0] ctrl_a_rd,
  output logic [CTRL_W-1:0] ctrl_b_rd,
  output logic [W-1:0]      cmp_rd,
  output logic [W-1:0]      cmp_act
);
  localparam logic [W-1:0]      TOP_VAL = '1;
  localparam logic [CTRL_W-1:0] A_MASK  = 8'hC3;
  localparam logic [CTRL_W-1:0] B_MASK  = 8'h08;
  localparam int                MODE_HI = 3;
  localparam int                OM_LSB  = 6;

  logic [CTRL_W-1:0] ctrl_a_q, ctrl_b_q;
  logic [W-1:0]      cmp_buf, cmp_nxt;

  assign kind      = decode_kind({ctrl_b_q[MODE_HI], ctrl_a_q[1:0]});
  assign om        = om_e'(ctrl_a_q[OM_LSB +: 2]);
  assign ctrl_a_rd = ctrl_a_q;
  assign ctrl_b_rd = ctrl_b_q;
  assign cmp_rd    = cmp_buf;
  assign cmp_nxt   = cmp_we ? cmp_wdata : cmp_buf;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
      cmp_buf  <= '0;
      cmp_act  <= '0;
    end else begin
      if (ctrl_a_we) ctrl_a_q <= ctrl_a_wdata & A_MASK;
      if (ctrl_b_we) ctrl_b_q <= ctrl_b_wdata & B_MASK;
      cmp_buf <= cmp_nxt;
      if (!is_pwm(kind) || cnt == TOP_VAL) cmp_act <= cmp_nxt;
    end
  end
endmodule

// File: rtl/cmpwave_counter.sv
module cmpwave_counter
  import cmpwave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  kind_e        kind,
  input  logic [W-1:0] cmp_act,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         ovf
);
  localparam logic [W-1:0] TOP_VAL = '1;
  localparam logic [W-1:0] BOTTOM  = '0;

  logic [W-1:0] cnt_nxt;
  logic         up_nxt, ovf_nxt;

  always_comb begin
    up_nxt = 1'b1;
    case (kind)
      KIND_PHASE: begin
        cnt_nxt = up ? cnt + 1'b1 : cnt - 1'b1;
        if (cnt_nxt == TOP_VAL)     up_nxt = 1'b0;
        else if (cnt_nxt == BOTTOM) up_nxt = 1'b1;
        else                        up_nxt = up;
      end
      KIND_CTC: cnt_nxt = (cnt == cmp_act) ? BOTTOM : cnt + 1'b1;
      default:  cnt_nxt = cnt + 1'b1;
    endcase
    if (is_pwm(kind)) ovf_nxt = (cnt != BOTTOM) && (cnt_nxt == BOTTOM);
    else              ovf_nxt = (cnt == TOP_VAL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= BOTTOM;
      up  <= 1'b1;
      ovf <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      up  <= up_nxt;
      ovf <= ovf_nxt;
    end
  end
endmodule

// File: rtl/cmpwave_wave.sv
module cmpwave_wave
  import cmpwave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  kind_e        kind,
  input  om_e          om,
  input  logic [W-1:0] cnt,
  input  logic         up,
  input  logic [W-1:0] cmp_act,
  output logic         wave_q,
  output logic         oe
);
  localparam logic [W-1:0] TOP_VAL = '1;

  logic hit, at_top, cmp_top, active, inv, wave_nxt;

  assign hit     = (cnt == cmp_act);
  assign at_top  = (cnt == TOP_VAL);
  assign cmp_top = (cmp_act == TOP_VAL);
  assign active  = (om == OM_LOW) || (om == OM_HIGH);
  assign inv     = (om == OM_HIGH);
  assign oe      = !((om == OM_OFF) || (is_pwm(kind) && om == OM_ALT));

  always_comb begin
    wave_nxt = wave_q;
    case (kind)
      KIND_FAST: begin
        if (active) begin
          if (hit && !cmp_top) wave_nxt = inv;
          else if (at_top)     wave_nxt = !inv;
        end
      end
      KIND_PHASE: begin
        if (active) begin
          if (hit && !cmp_top)       wave_nxt = up ? inv : !inv;
          else if (at_top && cmp_top) wave_nxt = !inv;
        end
      end
      default: begin
        if (hit) begin
          case (om)
            OM_ALT:  wave_nxt = !wave_q;
            OM_LOW:  wave_nxt = 1'b0;
            OM_HIGH: wave_nxt = 1'b1;
            default: wave_nxt = wave_q;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) wave_q <= 1'b0;
    else     wave_q <= wave_nxt;
  end
endmodule

// File: rtl/cmpwave_timer.sv
module cmpwave_timer
  import cmpwave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ctrl_a_we,
  input  logic [7:0]   ctrl_a_wdata,
  input  logic         ctrl_b_we,
  input  logic [7:0]   ctrl_b_wdata,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  output logic [7:0]   ctrl_a_rd,
  output logic [7:0]   ctrl_b_rd,
  output logic [W-1:0] cmp_rd,
  output logic [W-1:0] count,
  output logic         wave_out,
  output logic         wave_oe,
  output logic         match_flag,
  output logic         ovf_flag
);
  kind_e        kind;
  om_e          om;
  logic [W-1:0] cmp_act;
  logic         up, wave_q;

  cmpwave_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst),
    .ctrl_a_we(ctrl_a_we), .ctrl_a_wdata(ctrl_a_wdata),
    .ctrl_b_we(ctrl_b_we), .ctrl_b_wdata(ctrl_b_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .cnt(count), .kind(kind), .om(om),
    .ctrl_a_rd(ctrl_a_rd), .ctrl_b_rd(ctrl_b_rd),
    .cmp_rd(cmp_rd), .cmp_act(cmp_act)
  );

  cmpwave_counter #(.W(W)) u_counter (
    .clk(clk), .rst(rst), .kind(kind), .cmp_act(cmp_act),
    .cnt(count), .up(up), .ovf(ovf_flag)
  );

  cmpwave_wave #(.W(W)) u_wave (
    .clk(clk), .rst(rst), .kind(kind), .om(om), .cnt(count),
    .up(up), .cmp_act(cmp_act), .wave_q(wave_q), .oe(wave_oe)
  );

  assign match_flag = (count == cmp_act);
  assign wave_out   = wave_oe & wave_q;
endmodule

// File: rtl/cmpwave_timer_chk.sv
module cmpwave_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [7:0]   ctrl_a_rd,
  input logic [7:0]   ctrl_b_rd,
  input logic [W-1:0] count,
  input logic         wave_oe,
  input logic         match_flag,
  input logic         ovf_flag
);
  localparam logic [W-1:0] TOP_VAL = '1;

  logic [2:0] code;
  logic       is_ctc, is_fast, is_phase;
  assign code     = {ctrl_b_rd[3], ctrl_a_rd[1:0]};
  assign is_ctc   = (code == 3'b010);
  assign is_fast  = (code == 3'b011);
  assign is_phase = (code == 3'b001);

  assert_ovf_at_bottom_R3: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> (count == '0));

  assert_ctc_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (is_ctc && match_flag) |=> (count == '0));

  assert_fast_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (is_fast && count == TOP_VAL) |=> (count == '0));

  assert_phase_step_R7: assert property (@(posedge clk) disable iff (rst)
    (is_phase && $past(is_phase)) |->
      (count == W'($past(count) + 1'b1) || count == W'($past(count) - 1'b1)));

  assert_off_undriven_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_a_rd[7:6] == 2'b00) |-> !wave_oe);
endmodule

bind cmpwave_timer cmpwave_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ctrl_a_rd(ctrl_a_rd), .ctrl_b_rd(ctrl_b_rd),
  .count(count), .wave_oe(wave_oe), .match_flag(match_flag), .ovf_flag(ovf_flag)
);

// File: tb/cmpwave_timer_bench.sv
`timescale 1ns/1ps
module cmpwave_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_a_we = 1'b0, ctrl_b_we = 1'b0, cmp_we = 1'b0;
  logic [7:0] ctrl_a_wdata = '0, ctrl_b_wdata = '0, cmp_wdata = '0;
  logic [7:0] ctrl_a_rd, ctrl_b_rd, cmp_rd, count;
  logic       wave_out, wave_oe, match_flag, ovf_flag;
  int         vectors = 0, fails = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  cmpwave_timer u_cmpwave_timer (
    .clk(clk), .rst(rst),
    .ctrl_a_we(ctrl_a_we), .ctrl_a_wdata(ctrl_a_wdata),
    .ctrl_b_we(ctrl_b_we), .ctrl_b_wdata(ctrl_b_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .ctrl_a_rd(ctrl_a_rd), .ctrl_b_rd(ctrl_b_rd), .cmp_rd(cmp_rd),
    .count(count), .wave_out(wave_out), .wave_oe(wave_oe),
    .match_flag(match_flag), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (count=%0d)", tag, what, act, exp, count);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_a(input logic [7:0] v);
    ctrl_a_wdata = v; ctrl_a_we = 1'b1; @(negedge clk); ctrl_a_we = 1'b0;
  endtask
  task automatic wr_b(input logic [7:0] v);
    ctrl_b_wdata = v; ctrl_b_we = 1'b1; @(negedge clk); ctrl_b_we = 1'b0;
  endtask
  task automatic wr_cmp(input logic [7:0] v);
    cmp_wdata = v; cmp_we = 1'b1; @(negedge clk); cmp_we = 1'b0;
  endtask
  task automatic wait_count(input logic [7:0] v);
    for (int i = 0; i < 2000 && count !== v; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    chk("R1", "count", count, 0);
    chk("R1", "wave_out", wave_out, 0);
    chk("R1", "wave_oe", wave_oe, 0);
    chk("R1", "ovf_flag", ovf_flag, 0);
    chk("R1", "ctrl_a_rd", ctrl_a_rd, 0);
    chk("R1", "ctrl_b_rd", ctrl_b_rd, 0);
    chk("R1", "cmp_rd", cmp_rd, 0);
    rst = 1'b0;
  endtask

  // unused code 111 behaves as free running, action 11 sets on match
  task automatic t_other_code();
    logic [7:0] prev;
    wr_cmp(8'h40);
    wr_b(8'hFF);
    wr_a(8'hFF);
    chk("R2", "ctrl_a_rd reserved bits", ctrl_a_rd, 8'hC3);
    chk("R2", "ctrl_b_rd reserved bits", ctrl_b_rd, 8'h08);
    chk("R2", "cmp_rd", cmp_rd, 8'h40);
    prev = count;
    for (int i = 0; i < 600; i++) begin
      tick(1);
      chk("R4", "free-run step", count, 8'(prev + 8'd1));
      chk("R3", "ovf at wrap", ovf_flag, count == 8'd0);
      chk("R3", "match flag", match_flag, count == 8'h40);
      chk("R10", "oe driven", wave_oe, 1);
      prev = count;
    end
    chk("R5", "set on match", wave_out, 1);
  endtask

  task automatic t_ctc();
    logic [7:0] prev;
    logic       pw;
    wr_b(8'h00);
    wr_a(8'h42);
    wr_cmp(8'h20);
    tick(300);
    prev = count; pw = wave_out;
    for (int i = 0; i < 200; i++) begin
      tick(1);
      chk("R4", "ctc bound", count <= 8'h20, 1);
      chk("R4", "ctc sequence", count, (prev == 8'h20) ? 0 : 8'(prev + 8'd1));
      chk("R5", "toggle on match", wave_out, (prev == 8'h20) ? !pw : pw);
      chk("R3", "no ovf in ctc", ovf_flag, 0);
      chk("R10", "oe in ctc toggle", wave_oe, 1);
      prev = count; pw = wave_out;
    end
    wr_a(8'h82);
    tick(100);
    for (int i = 0; i < 50; i++) begin
      tick(1);
      chk("R5", "clear on match", wave_out, 0);
    end
    wr_a(8'hC2);
    tick(100);
    for (int i = 0; i < 50; i++) begin
      tick(1);
      chk("R5", "set on match ctc", wave_out, 1);
    end
  endtask

  task automatic t_fast(input logic [1:0] om, input logic [7:0] c, input string tag);
    logic [7:0] prev;
    int         exp;
    wr_cmp(c);
    wr_b(8'h00);
    wr_a({om, 6'b000011});
    tick(600);
    prev = count;
    for (int i = 0; i < 512; i++) begin
      tick(1);
      if (c == 8'hFF) exp = (om == 2'b10);
      else if (om == 2'b10) exp = (count <= c);
      else exp = (count > c);
      chk(tag, "fast pwm level", wave_out, exp);
      chk("R6", "fast step", count, 8'(prev + 8'd1));
      chk("R3", "ovf at bottom", ovf_flag, count == 8'd0);
      chk("R3", "match flag fast", match_flag, count == c);
      prev = count;
    end
  endtask

  task automatic t_phase(input logic [1:0] om, input logic [7:0] c, input string tag);
    logic [7:0] p1, p2, expc;
    wr_cmp(c);
    wr_b(8'h00);
    wr_a({om, 6'b000001});
    tick(1100);
    p2 = count; tick(1); p1 = count;
    for (int i = 0; i < 520; i++) begin
      tick(1);
      if (p1 == 8'hFF) expc = 8'hFE;
      else if (p1 == 8'h00) expc = 8'h01;
      else expc = (p1 > p2) ? 8'(p1 + 8'd1) : 8'(p1 - 8'd1);
      chk("R7", "phase step", count, expc);
      chk("R3", "ovf phase", ovf_flag, count == 8'd0);
      if (c == 8'hFF) chk(tag, "phase level top", wave_out, om == 2'b10);
      else if (count != c)
        chk(tag, "phase level", wave_out, (om == 2'b10) ? (count < c) : (count > c));
      p2 = p1; p1 = count;
    end
  endtask

  task automatic t_buffered();
    wr_cmp(8'd200);
    wr_b(8'h00);
    wr_a(8'h83);
    tick(600);
    wait_count(8'd50);
    wr_cmp(8'd20);
    chk("R11", "cmp_rd immediate", cmp_rd, 20);
    wait_count(8'd100);
    chk("R11", "old compare still governs level", wave_out, 1);
    wait_count(8'd200);
    chk("R11", "old compare still matches", match_flag, 1);
    wait_count(8'd20);
    chk("R11", "new compare matches after wrap", match_flag, 1);
    wait_count(8'd100);
    chk("R11", "new compare governs level", wave_out, 0);
  endtask

  task automatic t_disconnect();
    logic [7:0] codes [3] = '{8'h43, 8'h00, 8'h41};
    for (int k = 0; k < 3; k++) begin
      wr_a(codes[k]);
      for (int i = 0; i < 300; i++) begin
        tick(1);
        chk("R10", "oe low", wave_oe, 0);
        chk("R10", "pin low", wave_out, 0);
      end
    end
  endtask

  initial begin
    tick(1);
    t_reset();
    t_other_code();
    t_ctc();
    t_fast(2'b10, 8'd100, "R6");
    t_fast(2'b11, 8'd100, "R6");
    t_fast(2'b10, 8'hFF, "R9");
    t_fast(2'b11, 8'hFF, "R9");
    t_buffered();
    t_phase(2'b10, 8'd100, "R8");
    t_phase(2'b11, 8'd100, "R8");
    t_phase(2'b10, 8'hFF, "R9");
    t_phase(2'b11, 8'hFF, "R9");
    t_disconnect();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule